// File: doc/BRIEF.md
# Power-Management Sleep Control Register

This block is the 16-bit sleep control register of a power-management I/O block, on a simple byte-addressed I/O bus. Software can reach it with byte accesses to its low and high halves or with one 16-bit word access. The register holds an interrupt-routing enable, a global-release request bit, a three-bit sleep-type field and a sleep-enable strobe. The sleep-enable bit is never stored. Writing it as one, through a high-byte or word access, makes the block decode the sleep-type field from the written value into a platform action.

A suspend-to-RAM request raises a one-clock system-reset pulse and sets a sticky flag. The flag tells the firmware that it must resume from the suspended state. Hibernate and soft-off requests raise a one-clock shutdown-request pulse. The global-release and sleep-enable bits are write-only and always read back as zero. Reads complete in the same cycle as the read strobe.

Top module: `pm_ctrl_reg`

## Requirements
- R1: After a synchronous reset the register reads 0x0000, and the reset pulse, shutdown pulse and resume flag are all low.
- R2: A byte write (bus_word=0) at offset 4 replaces bits 7:0 with bus_wdata[7:0] and leaves bits 15:8 unchanged.
- R3: A read returns the stored value with bit 2 (global release) and bit 13 (sleep enable) forced to zero, in the same cycle as bus_rd. A word read at offset 4 returns all 16 bits. A byte read at offset 4 returns bits 7:0 and a byte read at offset 5 returns bits 15:8, in both cases on bus_rdata[7:0] with bus_rdata[15:8] zero.
- R4: A byte write at offset 5 replaces bits 15:8 with bus_wdata[7:0], stores bit 13 as zero and leaves bits 7:0 unchanged. The written byte's bit 5 is the sleep enable and its bits 4:2 are the sleep type.
- R5: A word write at offset 4 stores bus_wdata with bit 13 cleared. The sleep type is bus_wdata[12:10] and the sleep enable is bus_wdata[13].
- R6: A byte write at offset 4 never produces a reset or shutdown pulse, whatever its data.
- R7: A high-byte or word write with sleep enable set and sleep type 5 drives sys_reset_pulse high for exactly the cycle after the write and sets resume_s3_flag in that same cycle. Back-to-back such writes give one pulse cycle each.
- R8: A high-byte or word write with sleep enable set and sleep type 6 or 7 drives shutdown_req high for exactly the cycle after the write, without touching the resume flag.
- R9: A write with sleep enable clear, or with sleep enable set and a sleep type other than 5, 6 or 7, produces no pulse. Its data is still stored.
- R10: resume_s3_flag stays set until resume_clr is high at a clock edge. If a suspend request and resume_clr come in the same cycle, the flag stays set.
- R11: Writes to any other offset, and word accesses at offset 5, change nothing and produce no pulse. Reads there return 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address within the power-management block |
| bus_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| resume_clr | input | 1 | Clears the resume flag |
| bus_rdata | output | 16 | Read data, valid with bus_rd |
| sys_reset_pulse | output | 1 | One-cycle system reset for suspend-to-RAM |
| shutdown_req | output | 1 | One-cycle shutdown request for hibernate or soft-off |
| resume_s3_flag | output | 1 | Sticky resume-from-suspend indication |

## Verification
The bench aims at high-byte writes whose byte bit 5 lands on the sleep enable. If a design decodes the action from the old register contents or from an unshifted byte, it fires on the wrong type or fails to fire. Low-byte writes carry all-ones data: if the low lane leaks into the action logic, a pulse appears on a write that must never trigger one. Word and byte reads after sleep-type writes expose designs that store the enable bit or fail to mask global release. Back-to-back suspend writes, and a clear that coincides with a suspend request, expose wrong pulse widths and a wrong priority on the sticky flag. Random traffic that includes unmapped offsets and word accesses at offset 5 catches loose address decoding.

// File: rtl/pm_ctrl_pkg.sv
package pm_ctrl_pkg;
  localparam int REG_W      = 16;
  localparam int LANE_W     = 8;
  localparam int NUM_LANES  = REG_W / LANE_W;
  localparam int BIT_SCI    = 0;
  localparam int BIT_GREL   = 2;
  localparam int TYP_LSB    = 10;
  localparam int TYP_W      = 3;
  localparam int BIT_SLPEN  = 13;

  localparam logic [TYP_W-1:0] TYP_SUSPEND  = 3'd5;
  localparam logic [TYP_W-1:0] TYP_HIBERN   = 3'd6;
  localparam logic [TYP_W-1:0] TYP_SOFTOFF  = 3'd7;

  localparam logic [REG_W-1:0] SLPEN_MASK = REG_W'(1) << BIT_SLPEN;
  localparam logic [REG_W-1:0] WO_MASK    = (REG_W'(1) << BIT_GREL) | SLPEN_MASK;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_SUSPEND,
    ACT_SHUTDOWN
  } sleep_act_e;

  typedef enum logic [1:0] {
    RSEL_NONE,
    RSEL_LO,
    RSEL_HI,
    RSEL_WORD
  } rsel_e;

  function automatic sleep_act_e decode_sleep(input logic en, input logic [TYP_W-1:0] typ);
    sleep_act_e a;
    a = ACT_NONE;
    if (en) begin
      case (typ)
        TYP_SUSPEND:             a = ACT_SUSPEND;
        TYP_HIBERN, TYP_SOFTOFF: a = ACT_SHUTDOWN;
        default:                 a = ACT_NONE;
      endcase
    end
    return a;
  endfunction
endpackage

// File: rtl/pm_bus_decode.sv
module pm_bus_decode
  import pm_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CTRL_OFS = 4
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 word,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [REG_W-1:0]     wdata,
  output logic [NUM_LANES-1:0] lane_we,
  output logic                 act_we,
  output logic [REG_W-1:0]     wval,
  output rsel_e                rsel
);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(CTRL_OFS + 1);

  logic hit_lo_b, hit_hi_b, hit_w;

  always_comb begin
    hit_lo_b = (addr == A_LO) && !word;
    hit_hi_b = (addr == A_HI) && !word;
    hit_w    = (addr == A_LO) && word;
  end

  always_comb begin
    lane_we = '0;
    act_we  = 1'b0;
    wval    = '0;
    if (wr) begin
      if (hit_lo_b) begin
        lane_we[0] = 1'b1;
        wval       = {{LANE_W{1'b0}}, wdata[LANE_W-1:0]};
      end else if (hit_hi_b) begin
        lane_we[1] = 1'b1;
        act_we     = 1'b1;
        wval       = {wdata[LANE_W-1:0], {LANE_W{1'b0}}};
      end else if (hit_w) begin
        lane_we    = '1;
        act_we     = 1'b1;
        wval       = wdata;
      end
    end
  end

  always_comb begin
    rsel = RSEL_NONE;
    if (rd) begin
      if (hit_w)         rsel = RSEL_WORD;
      else if (hit_lo_b) rsel = RSEL_LO;
      else if (hit_hi_b) rsel = RSEL_HI;
    end
  end
endmodule

// File: rtl/pm_ctrl_store.sv
module pm_ctrl_store
  import pm_ctrl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LANES-1:0] lane_we,
  input  logic [REG_W-1:0]     wval,
  output logic [REG_W-1:0]     q
);
  logic [REG_W-1:0] wclean;

  always_comb wclean = wval & ~SLPEN_MASK;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)             q[g*LANE_W +: LANE_W] <= '0;
      else if (lane_we[g]) q[g*LANE_W +: LANE_W] <= wclean[g*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/pm_sleep_ctrl.sv
module pm_sleep_ctrl
  import pm_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             act_we,
  input  logic [REG_W-1:0] wval,
  input  logic             resume_clr,
  output logic             rst_pulse,
  output logic             off_pulse,
  output logic             resume_flag
);
  sleep_act_e act;

  always_comb begin
    act = ACT_NONE;
    if (act_we) act = decode_sleep(wval[BIT_SLPEN], wval[TYP_LSB +: TYP_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_pulse   <= 1'b0;
      off_pulse   <= 1'b0;
      resume_flag <= 1'b0;
    end else begin
      rst_pulse <= (act == ACT_SUSPEND);
      off_pulse <= (act == ACT_SHUTDOWN);
      if (act == ACT_SUSPEND) resume_flag <= 1'b1;
      else if (resume_clr)    resume_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg
  import pm_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CTRL_OFS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_word,
  input  logic              resume_clr,
  output logic [15:0]       bus_rdata,
  output logic              sys_reset_pulse,
  output logic              shutdown_req,
  output logic              resume_s3_flag
);
  logic [NUM_LANES-1:0] lane_we;
  logic                 act_we;
  logic [REG_W-1:0]     wval;
  logic [REG_W-1:0]     ctrl_q;
  logic [REG_W-1:0]     ctrl_vis;
  rsel_e                rsel;

  pm_bus_decode #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_dec (
    .addr    (bus_addr),
    .word    (bus_word),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .wdata   (bus_wdata),
    .lane_we (lane_we),
    .act_we  (act_we),
    .wval    (wval),
    .rsel    (rsel)
  );

  pm_ctrl_store u_store (
    .clk     (clk),
    .rst     (rst),
    .lane_we (lane_we),
    .wval    (wval),
    .q       (ctrl_q)
  );

  pm_sleep_ctrl u_sleep (
    .clk         (clk),
    .rst         (rst),
    .act_we      (act_we),
    .wval        (wval),
    .resume_clr  (resume_clr),
    .rst_pulse   (sys_reset_pulse),
    .off_pulse   (shutdown_req),
    .resume_flag (resume_s3_flag)
  );

  always_comb begin
    ctrl_vis = ctrl_q & ~WO_MASK;
    case (rsel)
      RSEL_WORD: bus_rdata = ctrl_vis;
      RSEL_LO:   bus_rdata = {{LANE_W{1'b0}}, ctrl_vis[LANE_W-1:0]};
      RSEL_HI:   bus_rdata = {{LANE_W{1'b0}}, ctrl_vis[REG_W-1:LANE_W]};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pm_ctrl_reg_chk.sv
module pm_ctrl_reg_chk #(
  parameter int ADDR_W   = 8,
  parameter int CTRL_OFS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_word,
  input logic              resume_clr,
  input logic [15:0]       bus_rdata,
  input logic              sys_reset_pulse,
  input logic              shutdown_req,
  input logic              resume_s3_flag
);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(CTRL_OFS);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sys_reset_pulse && !shutdown_req && !resume_s3_flag));

  p_wo_masked_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_word && bus_addr == A_LO) |-> (!bus_rdata[13] && !bus_rdata[2]));

  p_low_byte_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_word && bus_addr == A_LO) |=> (!sys_reset_pulse && !shutdown_req));

  p_reset_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
    sys_reset_pulse |-> resume_s3_flag);

  p_pulse_from_write_r7: assert property (@(posedge clk) disable iff (rst)
    (sys_reset_pulse || shutdown_req) |-> $past(bus_wr));

  p_pulses_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(sys_reset_pulse && shutdown_req));

  p_flag_fall_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(resume_s3_flag) |-> $past(resume_clr));

  p_flag_rise_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(resume_s3_flag) |-> sys_reset_pulse);

  p_no_word_hi_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_word && bus_addr != A_LO) |=> (!sys_reset_pulse && !shutdown_req));
endmodule

bind pm_ctrl_reg pm_ctrl_reg_chk #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .bus_addr        (bus_addr),
  .bus_wdata       (bus_wdata),
  .bus_wr          (bus_wr),
  .bus_rd          (bus_rd),
  .bus_word        (bus_word),
  .resume_clr      (resume_clr),
  .bus_rdata       (bus_rdata),
  .sys_reset_pulse (sys_reset_pulse),
  .shutdown_req    (shutdown_req),
  .resume_s3_flag  (resume_s3_flag)
);

// File: tb/pm_ctrl_reg_tb.sv
`timescale 1ns/1ps
module pm_ctrl_reg_tb;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_word = 1'b0, resume_clr = 1'b0;
  logic [15:0]   bus_rdata;
  logic          sys_reset_pulse, shutdown_req, resume_s3_flag;

  always #2.5 clk = ~clk;

  pm_ctrl_reg #(.ADDR_W(AW), .CTRL_OFS(4)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_word(bus_word), .resume_clr(resume_clr),
    .bus_rdata(bus_rdata), .sys_reset_pulse(sys_reset_pulse),
    .shutdown_req(shutdown_req), .resume_s3_flag(resume_s3_flag)
  );

  int          checks = 0;
  int          fails  = 0;
  logic [15:0] m_reg  = '0;
  logic        m_rp = 1'b0, m_sd = 1'b0, m_flag = 1'b0;
  string       prev_tag = "R1";

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [AW-1:0] a, input logic word);
    logic [15:0] vis;
    vis = m_reg & 16'hDFFB;
    if (word) return (a == 4) ? vis : 16'h0000;
    if (a == 4) return {8'h00, vis[7:0]};
    if (a == 5) return {8'h00, vis[15:8]};
    return 16'h0000;
  endfunction

  task automatic step(input logic [AW-1:0] a, input logic [15:0] wd, input logic wr,
                      input logic rd, input logic word, input logic clr, input string tag);
    logic [15:0] v;
    logic        act, s3, off;
    @(negedge clk);
    chk({prev_tag, " pulses/flag"}, {13'b0, sys_reset_pulse, shutdown_req, resume_s3_flag},
        {13'b0, m_rp, m_sd, m_flag});
    bus_addr = a; bus_wdata = wd; bus_wr = wr; bus_rd = rd; bus_word = word; resume_clr = clr;
    #1;
    if (rd) chk({tag, " rdata"}, bus_rdata, m_read(a, word));
    @(posedge clk);
    act = 1'b0; s3 = 1'b0; off = 1'b0; v = '0;
    if (wr) begin
      if (a == 4 && !word) m_reg[7:0] = wd[7:0];
      else if (a == 5 && !word) begin
        v = {wd[7:0], 8'h00}; m_reg[15:8] = wd[7:0] & 8'hDF; act = 1'b1;
      end else if (a == 4 && word) begin
        v = wd; m_reg = wd & 16'hDFFF; act = 1'b1;
      end
    end
    if (act && v[13]) begin
      if (v[12:10] == 3'd5) s3 = 1'b1;
      else if (v[12:10] == 3'd6 || v[12:10] == 3'd7) off = 1'b1;
    end
    m_rp = s3; m_sd = off;
    if (s3) m_flag = 1'b1;
    else if (clr) m_flag = 1'b0;
    prev_tag = tag;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step(4, 16'h0, 0, 1, 1, 0, "R1 reset word read");
    // R2 R6: low byte write with all-ones data
    step(4, 16'hFFFF, 1, 0, 0, 0, "R6 low byte all ones");
    step(4, 16'h0, 0, 1, 1, 0, "R2 R3 word read after low write");
    step(4, 16'h0, 0, 1, 0, 0, "R3 low byte read");
    // R4 R7: high byte 0x35 -> enable and type 5
    step(5, 16'h0035, 1, 0, 0, 0, "R4 R7 high byte suspend");
    step(5, 16'h0, 0, 1, 0, 0, "R3 R4 high byte read");
    step(4, 16'h0, 0, 1, 1, 0, "R4 word read after high write");
    step(4, 16'h0, 0, 0, 0, 1, "R10 clear flag");
    step(4, 16'h0, 0, 0, 0, 0, "R10 idle");
    // R5 R8: hibernate and soft-off by word
    step(4, 16'h3805, 1, 0, 1, 0, "R5 R8 word hibernate");
    step(4, 16'h0, 0, 1, 1, 0, "R5 word read");
    step(5, 16'h003C, 1, 0, 0, 0, "R8 high byte soft-off");
    // R9: no enable, or unused type
    step(4, 16'h1401, 1, 0, 1, 0, "R9 type 5 without enable");
    step(4, 16'h2000, 1, 0, 1, 0, "R9 enable with type 0");
    step(5, 16'h0030, 1, 0, 0, 0, "R9 high byte type 4");
    step(4, 16'h0, 0, 1, 1, 0, "R9 stored data");
    // R7: back-to-back suspend, R10 clear with set
    step(4, 16'h3401, 1, 0, 1, 0, "R7 back to back first");
    step(4, 16'h3401, 1, 0, 1, 1, "R7 R10 second with clear");
    step(4, 16'h0, 0, 0, 0, 1, "R10 clear after");
    // R11: unmapped offsets and word at 5
    step(6, 16'hFFFF, 1, 0, 0, 0, "R11 byte write offset 6");
    step(5, 16'h3C00, 1, 0, 1, 0, "R11 word write offset 5");
    step(3, 16'h3400, 1, 0, 1, 0, "R11 word write offset 3");
    step(5, 16'h0, 0, 1, 1, 0, "R11 word read offset 5");
    step(6, 16'h0, 0, 1, 0, 0, "R11 byte read offset 6");
    step(4, 16'h0, 0, 1, 1, 0, "R11 register unchanged");
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = AW'(3 + ($urandom % 4));
      step(a, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'(($urandom % 4) == 0), "R7 R8 R9 random traffic");
    end
    step(4, 16'h0, 0, 1, 1, 0, "R3 final read");
    summary();
    $finish;
  end
endmodule